// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block is the multi-cycle control unit of a small 16-bit CPU core that carries out the unconditional software-trap instruction. When the core presents an instruction word together with a start strobe, the block checks whether the word is a trap opcode. If it is, the block saves the return address and the condition codes on a descending stack. It then reads the handler address from a vector table and hands back the new program counter, the updated condition codes and the new stack pointer, together with a one-cycle done pulse.

Two addressing layouts are supported, and a mode input selects between them. In narrow mode, addresses, the program counter and the stack pointer are 16 bits and each vector entry is one word. In wide mode, addresses are 24 bits and each vector entry is a longword. Memory is reached through a word-wide request/ready port. The request and the data stay registered until the memory accepts them. Whatever the mode, the sequence lasts a fixed number of states, and only memory wait cycles lengthen it.

Top module: `trap_seq`

## Requirements
- R1: A start with an instruction word that is not a trap sets `bad_op` for exactly one cycle after the sampling edge. It issues no memory request, leaves `busy` low and leaves `pc_out`, `ccr_out` and `sp_out` unchanged. A trap word has 0x57 in bits 15:8 and zero in bits 7:6 and 3:0.
- R2: The vector number n is taken from instruction bits 5:4. The return value R is the instruction's PC plus 2. In narrow mode R is computed in 16 bits.
- R3: The first bus cycle writes R[15:0] to SP−2. The second writes a word to SP−4 whose bits 15:8 are the incoming CCR, before any change. Bits 7:0 of that word are R[23:16] in wide mode and zero in narrow mode.
- R4: In narrow mode the block makes one read, at 0x0010 + 2·n, and the new PC is that word zero-extended.
- R5: In wide mode the block makes two reads, first at 0x000020 + 4·n and then at that address + 2. The new PC is {first word[7:0], second word}.
- R6: `ccr_out` equals the incoming CCR with bit 7 set. Bit 6 is also set when `ubit_mask` is 1; otherwise it keeps its incoming value. The other six bits keep their incoming values.
- R7: `sp_out` is SP−4. In narrow mode it is computed in 16 bits with bits 23:16 zero.
- R8: `done` is a single-cycle pulse. It rises 13 rising edges after the edge that samples start, so the sequence spans 14 states, plus one edge for every cycle in which `mem_req` is high and `mem_ready` is low.
- R9: While `mem_req` is high and `mem_ready` is low, the request, `mem_we`, `mem_addr` and `mem_wdata` hold their values. Every address is even, and the two writes come before any read.
- R10: While the block is busy, start is ignored, and so are changes to `instr`, `pc_in`, `ccr_in`, `sp_in` and the mode inputs. A run produces exactly one done pulse and results computed from the values sampled at its start.
- R11: In narrow mode, bits 23:16 of every memory address are zero, even when `sp_in` carries nonzero upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a trap sequence with `instr` |
| instr | input | 16 | Instruction word (first byte in bits 15:8) |
| pc_in | input | 24 | Address of the trap instruction |
| ccr_in | input | 8 | Current condition-code register |
| sp_in | input | 24 | Current stack pointer |
| wide_mode | input | 1 | 1 = 24-bit layout, 0 = 16-bit layout |
| ubit_mask | input | 1 | 1 = CCR bit 6 acts as an interrupt mask |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Memory accepts or completes the access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_op | output | 1 | One-cycle pulse: start with a non-trap word |
| pc_out | output | 24 | Handler address |
| ccr_out | output | 8 | Updated condition codes |
| sp_out | output | 24 | Stack pointer after the saves |

## Verification
A wrong phase or a misplaced mode latch shows up on the bus within a few cycles of start: the bench sees a wrong address, a wrong data word or an out-of-order access in the log it keeps of each transfer. Faults in the state counter only show at the end. There, `done` rises earlier or later than 13 edges plus the counted stall edges, so a miscount is caught when the pulse arrives. The bench sweeps all four vector numbers in both modes, with the mask setting on and off and with stalls on and off. It uses wrap-around return addresses and garbage upper stack bits. In each run it compares every transfer and every output against values it computes itself.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEC,
    PH_WR0,
    PH_WR1,
    PH_RD0,
    PH_RD1,
    PH_PAD
  } phase_t;

  localparam logic [7:0] TRAP_OPC = 8'h57;
  localparam int IBIT = 7;
  localparam int UBIT = 6;
endpackage

// File: rtl/trap_decode.sv
module trap_decode #(
  parameter int IW = 16
) (
  input  logic [IW-1:0] instr,
  output logic          hit,
  output logic [1:0]    vec
);
  import trap_pkg::*;

  // first byte in the upper half, operand byte below
  always_comb begin
    hit = (instr[IW-1:IW-8] == TRAP_OPC) &&
          (instr[7:6] == 2'b00) && (instr[3:0] == 4'h0);
    vec = instr[5:4];
  end
endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen #(
  parameter int AW    = 24,
  parameter int NW    = 16,
  parameter int NBASE = 16,
  parameter int ABASE = 32
) (
  input  logic [AW-1:0] sp,
  input  logic [1:0]    vec,
  input  logic          wide,
  output logic [AW-1:0] push0,
  output logic [AW-1:0] push1,
  output logic [AW-1:0] vaddr0,
  output logic [AW-1:0] vaddr1,
  output logic [AW-1:0] sp_new
);
  localparam logic [AW-1:0] NMASK = {{(AW-NW){1'b0}}, {NW{1'b1}}};

  logic [AW-1:0] keep;
  logic [AW-1:0] vbase;

  always_comb begin
    keep   = wide ? {AW{1'b1}} : NMASK;
    push0  = (sp - AW'(2)) & keep;
    push1  = (sp - AW'(4)) & keep;
    sp_new = push1;
    vbase  = wide ? (AW'(ABASE) + AW'({vec, 2'b00}))
                  : (AW'(NBASE) + AW'({vec, 1'b0}));
    vaddr0 = vbase & keep;
    vaddr1 = (vbase + AW'(2)) & keep;
  end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int LEN = 14,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              wide,
  input  logic              xfer,
  input  logic              wait_bus,
  output trap_pkg::phase_t  phase,
  output logic              busy,
  output logic              finish
);
  import trap_pkg::*;

  logic [CW-1:0] cnt;

  assign busy   = (phase != PH_IDLE);
  assign finish = (phase == PH_PAD) && (cnt == CW'(LEN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      if (phase == PH_IDLE) begin
        if (go) begin
          phase <= PH_DEC;
          cnt   <= CW'(1);
        end
      end else begin
        if (!wait_bus) cnt <= cnt + CW'(1);
        unique case (phase)
          PH_DEC: phase <= PH_WR0;
          PH_WR0: if (xfer) phase <= PH_WR1;
          PH_WR1: if (xfer) phase <= PH_RD0;
          PH_RD0: if (xfer) phase <= wide ? PH_RD1 : PH_PAD;
          PH_RD1: if (xfer) phase <= PH_PAD;
          PH_PAD: if (finish) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CW'(LEN - 1)));

  // R8
  pad_exit_chk: assert property (@(posedge clk) disable iff (rst)
    finish |=> (phase == PH_IDLE));
endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int NW    = 16,
  parameter int LEN   = 14,
  parameter int NBASE = 16,
  parameter int ABASE = 32,
  localparam int HB   = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [15:0]   instr,
  input  logic [AW-1:0] pc_in,
  input  logic [7:0]    ccr_in,
  input  logic [AW-1:0] sp_in,
  input  logic          wide_mode,
  input  logic          ubit_mask,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          bad_op,
  output logic [AW-1:0] pc_out,
  output logic [7:0]    ccr_out,
  output logic [AW-1:0] sp_out
);
  import trap_pkg::*;

  phase_t        phase;
  logic          finish;
  logic          hit;
  logic [1:0]    vec_dec;
  logic          go, bad, xfer, wait_bus;

  logic [AW-1:0] ret_l, sp_l;
  logic [7:0]    ccr_l;
  logic [1:0]    vec_l;
  logic          wide_l, umask_l;
  logic [DW-1:0] vhi, vlo;

  logic [AW-1:0] push0, push1, vaddr0, vaddr1, sp_new;
  logic [AW-1:0] ret_next;

  trap_decode #(.IW(16)) dec_i (
    .instr(instr), .hit(hit), .vec(vec_dec)
  );

  trap_addr_gen #(.AW(AW), .NW(NW), .NBASE(NBASE), .ABASE(ABASE)) agen_i (
    .sp(sp_l), .vec(vec_l), .wide(wide_l),
    .push0(push0), .push1(push1), .vaddr0(vaddr0), .vaddr1(vaddr1),
    .sp_new(sp_new)
  );

  trap_ctrl #(.LEN(LEN)) ctrl_i (
    .clk(clk), .rst(rst), .go(go), .wide(wide_l), .xfer(xfer),
    .wait_bus(wait_bus), .phase(phase), .busy(busy), .finish(finish)
  );

  always_comb begin
    go       = start && !busy && hit;
    bad      = start && !busy && !hit;
    xfer     = mem_req && mem_ready;
    wait_bus = mem_req && !mem_ready;
    ret_next = wide_mode ? (pc_in + AW'(2))
                         : AW'(pc_in[NW-1:0] + NW'(2));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      bad_op    <= 1'b0;
      pc_out    <= '0;
      ccr_out   <= '0;
      sp_out    <= '0;
      ret_l     <= '0;
      sp_l      <= '0;
      ccr_l     <= '0;
      vec_l     <= '0;
      wide_l    <= 1'b0;
      umask_l   <= 1'b0;
      vhi       <= '0;
      vlo       <= '0;
    end else begin
      done   <= 1'b0;
      bad_op <= bad;
      if (go) begin
        ret_l   <= ret_next;
        sp_l    <= sp_in;
        ccr_l   <= ccr_in;
        vec_l   <= vec_dec;
        wide_l  <= wide_mode;
        umask_l <= ubit_mask;
      end
      unique case (phase)
        PH_DEC: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= push0;
          mem_wdata <= ret_l[DW-1:0];
        end
        PH_WR0: if (xfer) begin
          mem_addr  <= push1;
          mem_wdata <= {ccr_l, (wide_l ? ret_l[AW-1:DW] : HB'(0))};
        end
        PH_WR1: if (xfer) begin
          mem_we   <= 1'b0;
          mem_addr <= vaddr0;
        end
        PH_RD0: if (xfer) begin
          vhi <= mem_rdata;
          if (wide_l) mem_addr <= vaddr1;
          else        mem_req  <= 1'b0;
        end
        PH_RD1: if (xfer) begin
          vlo     <= mem_rdata;
          mem_req <= 1'b0;
        end
        PH_PAD: if (finish) begin
          pc_out  <= wide_l ? {vhi[HB-1:0], vlo} : AW'(vhi);
          ccr_out <= ccr_l | (8'h01 << IBIT) |
                     (umask_l ? (8'h01 << UBIT) : 8'h00);
          sp_out  <= sp_new;
          done    <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

  // R9
  even_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  ibit_set_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ccr_out[IBIT]);

  // R1
  bad_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bad_op |-> (!mem_req && !busy));

  // R11
  narrow_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !wide_l) |-> (mem_addr[AW-1:NW] == '0));

  // R10
  idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

// File: tb/trap_seq_tb_top.sv
module trap_seq_tb_top;
  localparam int LEN = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [23:0] pc_in = '0;
  logic [7:0]  ccr_in = '0;
  logic [23:0] sp_in = '0;
  logic        wide_mode = 1'b0;
  logic        ubit_mask = 1'b0;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_ready = 1'b1;
  logic        busy, done, bad_op;
  logic [23:0] pc_out, sp_out;
  logic [7:0]  ccr_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int log_n = 0;
  int stall_n = 0;
  int done_n = 0;
  bit stall_en = 1'b0;
  logic [23:0] lg_addr [0:7];
  logic [15:0] lg_data [0:7];
  logic        lg_we   [0:7];
  logic [15:0] mem [0:4095];

  always #5 clk = ~clk;

  trap_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_in(pc_in),
    .ccr_in(ccr_in), .sp_in(sp_in), .wide_mode(wide_mode),
    .ubit_mask(ubit_mask), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .busy(busy), .done(done), .bad_op(bad_op),
    .pc_out(pc_out), .ccr_out(ccr_out), .sp_out(sp_out)
  );

  assign mem_rdata = mem[mem_addr[12:1]];

  always @(negedge clk) mem_ready <= !stall_en || ((cyc % 3) != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) done_n <= done_n + 1;
    if (mem_req && !mem_ready) stall_n <= stall_n + 1;
    if (mem_req && mem_ready) begin
      if (log_n < 8) begin
        lg_addr[log_n] <= mem_addr;
        lg_data[log_n] <= mem_we ? mem_wdata : mem_rdata;
        lg_we[log_n]   <= mem_we;
      end
      log_n <= log_n + 1;
      if (mem_we) mem[mem_addr[12:1]] <= mem_wdata;
    end
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL R8 watchdog expired act %0d exp <150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nvec(input int v);
    return 16'h4000 + 16'(v * 16'h0102);
  endfunction
  function automatic logic [15:0] avec_lo(input int v);
    return 16'h1234 + 16'(v * 16'h1111);
  endfunction

  task automatic run_case(input bit wide, input bit um, input int v,
                          input bit stl, input bit poke);
    logic [23:0] pc, sp, ret, ppc, psp, va;
    logic [7:0]  cc, pcc;
    int n;
    pc  = (v == 3) ? (wide ? 24'h12FFFE : 24'h00FFFE) : 24'h003450 + 24'(v * 24'h222);
    sp  = wide ? 24'h001800 : 24'hAB0800;
    cc  = 8'h15 + 8'(v * 8'h23);
    ret = wide ? pc + 24'd2 : {8'h00, pc[15:0] + 16'd2};
    psp = wide ? sp - 24'd4 : {8'h00, sp[15:0] - 16'd4};
    va  = wide ? 24'h000020 + 24'(4 * v) : 24'h000010 + 24'(2 * v);
    ppc = wide ? {8'h30 + 8'(v), avec_lo(v)} : {8'h00, nvec(v)};
    pcc = cc | 8'h80 | (um ? 8'h40 : 8'h00);

    @(negedge clk);
    stall_en = stl;
    wide_mode = wide; ubit_mask = um;
    pc_in = pc; sp_in = sp; ccr_in = cc;
    instr = 16'h5700 | 16'(v << 4);
    start = 1'b1;
    log_n = 0; stall_n = 0; done_n = 0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (1) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (poke && n == 3) begin
        start = 1'b1; instr = 16'h5730; pc_in = '0; sp_in = '0;
        ccr_in = 8'hFF; wide_mode = !wide; ubit_mask = !um;
      end else start = 1'b0;
      if (done || n > 400) break;
    end
    // R8: 13 edges after the start edge plus counted stalls
    chk(n == LEN - 1 + stall_n, "R8 cycle count", n, LEN - 1 + stall_n);
    chk(log_n == (wide ? 4 : 3), "R9 transfer count", log_n, wide ? 4 : 3);
    // R3 push order and contents
    chk(lg_we[0] && lg_addr[0] == (wide ? sp - 24'd2 : {8'h0, sp[15:0] - 16'd2}),
        "R3 first push addr", lg_addr[0], sp - 24'd2);
    chk(lg_data[0] == ret[15:0], "R2 pushed return low", lg_data[0], ret[15:0]);
    chk(lg_we[1] && lg_addr[1] == psp, "R3 second push addr", lg_addr[1], psp);
    chk(lg_data[1] == {cc, wide ? ret[23:16] : 8'h00}, "R3 pushed ccr word",
        lg_data[1], {cc, wide ? ret[23:16] : 8'h00});
    // R4 / R5 vector fetch
    chk(!lg_we[2] && lg_addr[2] == va, wide ? "R5 vector addr" : "R4 vector addr",
        lg_addr[2], va);
    if (wide)
      chk(!lg_we[3] && lg_addr[3] == va + 24'd2, "R5 second vector addr",
          lg_addr[3], va + 24'd2);
    chk(pc_out == ppc, wide ? "R5 new pc" : "R4 new pc", pc_out, ppc);
    chk(ccr_out == pcc, "R6 ccr", ccr_out, pcc);
    chk(sp_out == psp, "R7 sp", sp_out, psp);
    // R11 narrow addresses stay in 16 bits
    if (!wide)
      chk(lg_addr[0][23:16] == 0 && lg_addr[1][23:16] == 0, "R11 upper addr bits",
          {lg_addr[0][23:16], lg_addr[1][23:16]}, 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done && done_n == 1, "R8 done single pulse", done_n, 1);
    chk(!busy && !mem_req, "R10 idle after run", {busy, mem_req}, 0);
    if (poke) chk(log_n == (wide ? 4 : 3), "R10 start ignored while busy", log_n,
                  wide ? 4 : 3);
  endtask

  task automatic bad_case(input logic [15:0] w);
    logic [23:0] p0, s0;
    logic [7:0]  c0;
    p0 = pc_out; s0 = sp_out; c0 = ccr_out;
    @(negedge clk);
    instr = w; start = 1'b1; log_n = 0; done_n = 0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(bad_op == 1'b1, "R1 bad_op raised", bad_op, 1);
    chk(busy == 1'b0, "R1 stays idle", busy, 0);
    @(posedge clk);
    @(negedge clk);
    chk(bad_op == 1'b0, "R1 bad_op one cycle", bad_op, 0);
    repeat (3) @(negedge clk);
    chk(log_n == 0 && done_n == 0, "R1 no bus activity", log_n, 0);
    chk(pc_out == p0 && sp_out == s0 && ccr_out == c0, "R1 outputs kept",
        pc_out, p0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    for (int v = 0; v < 4; v++) begin
      mem[(16 + 2 * v) >> 1]     = nvec(v);
      mem[(32 + 4 * v) >> 1]     = {8'hC3, 8'h30 + 8'(v)};
      mem[(32 + 4 * v + 2) >> 1] = avec_lo(v);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !bad_op, "R8 reset idle",
        {busy, done, mem_req, bad_op}, 0);
    chk(pc_out == 0 && sp_out == 0 && ccr_out == 0, "R7 reset outputs",
        pc_out, 0);
    for (int w = 0; w < 2; w++)
      for (int u = 0; u < 2; u++)
        for (int st = 0; st < 2; st++)
          for (int v = 0; v < 4; v++)
            run_case(w[0], u[0], v, st[0], st == 1 && v == 1);
    bad_case(16'h5600);
    bad_case(16'h5740);
    bad_case(16'h5701);
    bad_case(16'h5788);
    bad_case(16'hD700);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule